// File: doc/BRIEF.md
# Supply Lockout Gate for a Half-Bridge Driver

This block sits between the filtered channel commands of a half-bridge gate driver and its two output stages. It passes each command through unchanged while the supplies are healthy. It blocks the commands when a supply is too low to drive the power switches fully, or when the switch node has swung too far below ground.

Each of the two supply domains has a lockout tracker fed by two comparator flags: "below the rising threshold" and "below the falling threshold". A domain enters lockout when its supply falls under the lower threshold. It leaves lockout only once the supply is back above the upper threshold, so the hysteresis band is realised in logic. A logic-supply lockout blocks both outputs and drives the active-low fault output low. A floating-supply lockout blocks only the high-side output.

A switch-node excursion below its negative limit that lasts long enough starts a timed hold-off of the high side. Every further qualified excursion restarts the hold-off.

Top module: `supply_lockout_gate`

## Requirements
- R1: While reset is asserted, both domains are in lockout: hiEnable = 0, loEnable = 0 and faultN = 0, whatever the commands are.
- R2: A locked logic domain leaves lockout at the first clock edge at which logicBelowRise is sampled 0. From then on faultN = 1.
- R3: In an unlocked logic domain, logicBelowFall sampled 1 at a clock edge locks the domain. After that edge, faultN = 0 and both enables are 0 for every command pattern.
- R4: While logicBelowRise = 1 and logicBelowFall = 0, the logic domain keeps whichever state it was in, locked or unlocked.
- R5: A floating-supply lockout is entered when floatBelowFall is sampled 1, and it forces only hiEnable to 0. loEnable and faultN are unaffected by it.
- R6: A locked floating domain stays locked while floatBelowRise = 1. It unlocks at the first edge at which floatBelowRise is sampled 0. An unlocked floating domain stays unlocked while floatBelowFall = 0.
- R7: A hold-off starts only when nodeBelowLimit has been sampled 1 on QUAL_CYC consecutive clock edges. A shorter run has no effect on hiEnable.
- R8: After the last edge that qualifies an excursion, hiEnable stays 0 for exactly HOLD_CYC clock edges and then follows hiCmd again. loEnable is unaffected throughout.
- R9: A new qualified excursion during a running hold-off restarts it with a full HOLD_CYC count.
- R10: With both domains unlocked and no hold-off running, hiEnable = hiCmd and loEnable = loCmd, combinationally and non-inverted, for all four command patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset; it puts both domains into lockout |
| hiCmd | input | 1 | Filtered high-side command, active high |
| loCmd | input | 1 | Filtered low-side command, active high |
| logicBelowRise | input | 1 | Logic supply is under its rising threshold |
| logicBelowFall | input | 1 | Logic supply is under its falling threshold |
| floatBelowRise | input | 1 | Floating supply is under its rising threshold |
| floatBelowFall | input | 1 | Floating supply is under its falling threshold |
| nodeBelowLimit | input | 1 | Switch node is below its negative limit |
| hiEnable | output | 1 | High-side output enable |
| loEnable | output | 1 | Low-side output enable |
| faultN | output | 1 | Active-low logic-supply fault |

## Verification
The bench builds the block with QUAL_CYC = 3 and HOLD_CYC = 6 instead of the defaults of 13 and 1125. With these values it can sweep every excursion length from 1 to QUAL_CYC + 1 and check the full hold-off window of each one edge by edge. The short hold-off also lets a second excursion land while the first hold-off is still running, which shows whether the count restarts. Each lockout state and each hysteresis band is combined with all four command patterns.

// File: rtl/supply_gate_pkg.sv
package supply_gate_pkg;

  // Domain indices for the two lockout trackers
  localparam int LOGIC_DOM = 0;
  localparam int FLOAT_DOM = 1;
  localparam int NUM_DOM   = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic logicLock;   // logic supply domain in lockout
    logic floatLock;   // floating supply domain in lockout
    logic holdLoad;    // qualified negative switch-node excursion
  } gateStrobes_t;

endpackage

// File: rtl/supply_gate_lock.sv
module supply_gate_lock (
  input  logic clk,
  input  logic rstN,
  input  logic belowRise,
  input  logic belowFall,
  output logic locked
);

  // Enter on the falling threshold, leave on the rising threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       locked <= 1'b1;
    else if (locked) locked <= belowRise;
    else             locked <= belowFall;
  end

endmodule

// File: rtl/supply_gate_ctrl.sv
module supply_gate_ctrl
  import supply_gate_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 13
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         logicBelowRise,
  input  logic         logicBelowFall,
  input  logic         floatBelowRise,
  input  logic         floatBelowFall,
  input  logic         nodeBelowLimit,
  output gateStrobes_t strobes
);

  localparam int QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC - 1);

  logic [NUM_DOM-1:0] riseVec;
  logic [NUM_DOM-1:0] fallVec;
  logic [NUM_DOM-1:0] lockVec;

  assign riseVec[LOGIC_DOM] = logicBelowRise;
  assign fallVec[LOGIC_DOM] = logicBelowFall;
  assign riseVec[FLOAT_DOM] = floatBelowRise;
  assign fallVec[FLOAT_DOM] = floatBelowFall;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    supply_gate_lock u_lock (
      .clk       (clk),
      .rstN      (rstN),
      .belowRise (riseVec[d]),
      .belowFall (fallVec[d]),
      .locked    (lockVec[d])
    );
  end

  // Consecutive-sample qualifier for the switch-node flag
  logic [QW-1:0] qualCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               qualCnt <= '0;
    else if (!nodeBelowLimit) qualCnt <= '0;
    else if (qualCnt != QMAX) qualCnt <= qualCnt + 1'b1;
  end

  always_comb begin
    strobes.logicLock = lockVec[LOGIC_DOM];
    strobes.floatLock = lockVec[FLOAT_DOM];
    strobes.holdLoad  = nodeBelowLimit && (qualCnt == QMAX);
  end

endmodule

// File: rtl/supply_gate_dp.sv
module supply_gate_dp
  import supply_gate_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 1125
) (
  input  logic         clk,
  input  logic         rstN,
  input  gateStrobes_t strobes,
  input  logic         hiCmd,
  input  logic         loCmd,
  output logic         hiEnable,
  output logic         loEnable,
  output logic         faultN
);

  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HLOAD = HW'(HOLD_CYC);

  logic [HW-1:0] holdCnt;
  logic          holdActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdCnt <= '0;
    else if (strobes.holdLoad) holdCnt <= HLOAD;
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end

  assign holdActive = (holdCnt != '0);

  always_comb begin
    faultN   = !strobes.logicLock;
    loEnable = loCmd && !strobes.logicLock;
    hiEnable = hiCmd && !strobes.logicLock && !strobes.floatLock && !holdActive;
  end

endmodule

// File: rtl/supply_lockout_gate.sv
module supply_lockout_gate
  import supply_gate_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 13,
  parameter int unsigned HOLD_CYC = 1125
) (
  input  logic clk,
  input  logic rstN,
  input  logic hiCmd,
  input  logic loCmd,
  input  logic logicBelowRise,
  input  logic logicBelowFall,
  input  logic floatBelowRise,
  input  logic floatBelowFall,
  input  logic nodeBelowLimit,
  output logic hiEnable,
  output logic loEnable,
  output logic faultN
);

  gateStrobes_t strobes;

  supply_gate_ctrl #(.QUAL_CYC(QUAL_CYC)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .logicBelowRise (logicBelowRise),
    .logicBelowFall (logicBelowFall),
    .floatBelowRise (floatBelowRise),
    .floatBelowFall (floatBelowFall),
    .nodeBelowLimit (nodeBelowLimit),
    .strobes        (strobes)
  );

  supply_gate_dp #(.HOLD_CYC(HOLD_CYC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .hiCmd    (hiCmd),
    .loCmd    (loCmd),
    .hiEnable (hiEnable),
    .loEnable (loEnable),
    .faultN   (faultN)
  );

endmodule

// File: rtl/supply_gate_chk.sv
module supply_gate_chk #(
  parameter int unsigned QUAL_CYC = 13
) (
  input logic clk,
  input logic rstN,
  input logic hiCmd,
  input logic loCmd,
  input logic logicBelowRise,
  input logic logicBelowFall,
  input logic floatBelowFall,
  input logic nodeBelowLimit,
  input logic hiEnable,
  input logic loEnable,
  input logic faultN
);

  localparam int RW = $clog2(QUAL_CYC + 1);

  // Run length of consecutive low-node samples, saturating
  logic [RW-1:0] belowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         belowRun <= '0;
    else if (!nodeBelowLimit)          belowRun <= '0;
    else if (belowRun != RW'(QUAL_CYC)) belowRun <= belowRun + 1'b1;
  end

  // R2
  fault_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!faultN && !logicBelowRise) |=> faultN);

  // R3
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultN && logicBelowFall) |=> !faultN);

  // R3
  fault_blocks_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |-> (!hiEnable && !loEnable));

  // R4
  fault_hyst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!faultN && logicBelowRise) |=> !faultN);

  // R5
  float_lock_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultN && floatBelowFall) |=> !hiEnable);

  // R5
  lo_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultN |-> (loEnable == loCmd));

  // R7
  qualified_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nodeBelowLimit && (belowRun >= RW'(QUAL_CYC - 1))) |=> !hiEnable);

  // R10
  hi_in_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiEnable |-> hiCmd);

endmodule

bind supply_lockout_gate supply_gate_chk #(.QUAL_CYC(QUAL_CYC)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .hiCmd          (hiCmd),
  .loCmd          (loCmd),
  .logicBelowRise (logicBelowRise),
  .logicBelowFall (logicBelowFall),
  .floatBelowFall (floatBelowFall),
  .nodeBelowLimit (nodeBelowLimit),
  .hiEnable       (hiEnable),
  .loEnable       (loEnable),
  .faultN         (faultN)
);

// File: tb/test_supply_lockout_gate.sv
`timescale 1ns/100ps
module test_supply_lockout_gate;

  localparam int Q = 3;
  localparam int H = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rstN, hiCmd, loCmd;
  logic logicBelowRise, logicBelowFall, floatBelowRise, floatBelowFall;
  logic nodeBelowLimit;
  logic hiEnable, loEnable, faultN;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  supply_lockout_gate #(.QUAL_CYC(Q), .HOLD_CYC(H)) i_supply_lockout_gate (
    .clk(clk), .rstN(rstN), .hiCmd(hiCmd), .loCmd(loCmd),
    .logicBelowRise(logicBelowRise), .logicBelowFall(logicBelowFall),
    .floatBelowRise(floatBelowRise), .floatBelowFall(floatBelowFall),
    .nodeBelowLimit(nodeBelowLimit),
    .hiEnable(hiEnable), .loEnable(loEnable), .faultN(faultN)
  );

  // Compare {hiEnable, loEnable, faultN}
  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {hiEnable, loEnable, faultN};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual hi/lo/fault=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // All four command patterns; hiOk = high side allowed, ok = logic unlocked
  task automatic sweepCmd(input string req, input bit hiOk, input bit ok);
    for (int c = 0; c < 4; c++) begin
      hiCmd = c[1];
      loCmd = c[0];
      #0.2;
      check(req, {c[1] & hiOk & ok, c[0] & ok, ok});
    end
    hiCmd = 1'b1;
    loCmd = 1'b1;
    #0.1;
  endtask

  // Hold-off window after the last qualifying edge
  task automatic holdWindow(input string req, input bit loaded);
    for (int j = 0; j <= H; j++) begin
      #0.5;
      check(req, {(!loaded || j >= H), 1'b1, 1'b1});
      tick();
    end
  endtask

  initial begin
    rstN = 1'b0; hiCmd = 1'b1; loCmd = 1'b1;
    logicBelowRise = 1'b0; logicBelowFall = 1'b0;
    floatBelowRise = 1'b0; floatBelowFall = 1'b0;
    nodeBelowLimit = 1'b0;
    tick(); tick();
    // R1: reset lockout with commands active
    sweepCmd("R1", 1'b0, 1'b0);

    // R4: release reset with logic supply between thresholds
    logicBelowRise = 1'b1;
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R4 locked band", 3'b000);
    end
    // R2: crossing the rising threshold releases
    logicBelowRise = 1'b0;
    tick();
    check("R2", 3'b111);
    // R10: pass-through
    sweepCmd("R10", 1'b1, 1'b1);

    // R4: unlocked domain holds inside the band
    logicBelowRise = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R4 open band", 3'b111);
    end
    // R3: falling threshold locks both
    logicBelowFall = 1'b1;
    tick();
    sweepCmd("R3", 1'b1, 1'b0);
    logicBelowFall = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      sweepCmd("R4 relock band", 1'b1, 1'b0);
    end
    logicBelowRise = 1'b0;
    tick();
    sweepCmd("R2 recover", 1'b1, 1'b1);

    // R6: floating supply in band while unlocked
    floatBelowRise = 1'b1;
    tick(); tick();
    sweepCmd("R6 open band", 1'b1, 1'b1);
    // R5: floating lockout blocks only high side
    floatBelowFall = 1'b1;
    tick();
    sweepCmd("R5", 1'b0, 1'b1);
    floatBelowFall = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      sweepCmd("R6 locked band", 1'b0, 1'b1);
    end
    floatBelowRise = 1'b0;
    tick();
    sweepCmd("R6 release", 1'b1, 1'b1);

    // R7/R8: excursion lengths 1..Q+1
    for (int w = 1; w <= Q + 1; w++) begin
      nodeBelowLimit = 1'b1;
      repeat (w) tick();
      nodeBelowLimit = 1'b0;
      holdWindow((w < Q) ? "R7 short" : "R8 window", w >= Q);
    end

    // R9: retrigger during hold-off
    nodeBelowLimit = 1'b1;
    repeat (Q) tick();
    nodeBelowLimit = 1'b0;
    tick(); tick();
    nodeBelowLimit = 1'b1;
    repeat (Q) tick();
    nodeBelowLimit = 1'b0;
    holdWindow("R9", 1'b1);
    sweepCmd("R10 after hold", 1'b1, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule